// File: doc/BRIEF.md
# Set-Less-Than and Leading-Bit Count Unit

This block is a combinational helper for the execute stage of a 32-bit pipeline. It takes the raw instruction word together with the two register operands that have already been read, and it returns a 32-bit result, a write-back enable and the index of the destination register. Four compare operations produce a 0/1 flag: signed and unsigned, each in a register-register form and a register-immediate form. Two count operations return the length of the run of zeros or of ones at the top of the first operand.

The instruction word uses the usual fields. The major opcode sits in bits 31:26 and the function code in bits 5:0. The source index `rt` is in bits 20:16 and the destination index `rd` is in bits 15:11. The 16-bit immediate is in bits 15:0. An internal decoder maps each recognised encoding to an operation kind. A magnitude comparator and a leading-run counter then work in parallel, and the top level chooses between their outputs. Every other encoding, and every cycle with reset held, gives a result of zero with write-back off.

Top module: `slc_exec_unit`

## Requirements
- R1: With major opcode 6'b000000 and function 6'b101010, the result is 1 when `rs_val < rt_val` as signed 32-bit values and 0 otherwise. Write-back is on and the destination is instruction bits 15:11.
- R2: With major opcode 6'b000000 and function 6'b101011, the result is 1 when `rs_val < rt_val` as unsigned values and 0 otherwise. Write-back is on and the destination is bits 15:11.
- R3: With major opcode 6'b001010, instruction bits 15:0 are sign-extended to 32 bits and compared with `rs_val` as signed values, giving 1 or 0. Write-back is on and the destination is bits 20:16.
- R4: With major opcode 6'b001011, the immediate is sign-extended to 32 bits and the two values are then compared as unsigned, giving 1 or 0. Write-back is on and the destination is bits 20:16.
- R5: With major opcode 6'b011100 and function 6'b100000, the result is the number of zero bits in `rs_val` counted from bit 31 down to the first 1. An all-zero operand gives 32. Write-back is on and the destination is bits 15:11.
- R6: With major opcode 6'b011100 and function 6'b100001, the result is the number of one bits in `rs_val` counted from bit 31 down to the first 0. An all-ones operand gives 32. Write-back is on and the destination is bits 15:11.
- R7: A compare result is zero-extended, so bits 31:1 of the result are always 0 for the four compare operations.
- R8: Any other combination of major opcode and function gives a result of 0, `wb_en` low and `wb_addr` of 0.
- R9: While `rst` is high, the result is 0, `wb_en` is low and `wb_addr` is 0, whatever the instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Synchronous-domain reset level; forces outputs idle |
| instr | input | 32 | Instruction word being executed |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand (register forms only) |
| result | output | 32 | Value to write back |
| wb_en | output | 1 | Destination register write enable |
| wb_addr | output | 5 | Destination register index |

## Verification
The compare sweeps cover every ordered pair from a set of boundary operands: zero, one, all ones, the most positive and most negative values, and their neighbours. A design that mixed up signed and unsigned ordering would fail on the pairs that straddle bit 31. A design that zero-extended the immediate would fail on negative immediates in the unsigned immediate form.

The count sweeps place the first set bit, or the first clear bit, at each of the 32 positions, with noise in the lower bits. They also apply the all-zero and all-ones operands. An off-by-one count, or a count that ignored the noise, would miss at once, and a design that stopped at 31 would miss the full-run case. All 64 major opcodes and all 64 function codes in both groups are swept to catch stray decodes. Destination selection is checked for each form, so a design that wrote an immediate compare to `rd` would be caught.

// File: rtl/slc_pkg.sv
package slc_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned OPC_W   = 6;
    localparam int unsigned REGIX_W = 5;
    localparam int unsigned IMM_W   = 16;

    localparam logic [OPC_W-1:0] MAJ_REGGRP = 6'b000000;
    localparam logic [OPC_W-1:0] MAJ_SLTI   = 6'b001010;
    localparam logic [OPC_W-1:0] MAJ_SLTIU  = 6'b001011;
    localparam logic [OPC_W-1:0] MAJ_EXTGRP = 6'b011100;

    localparam logic [OPC_W-1:0] FN_SLT  = 6'b101010;
    localparam logic [OPC_W-1:0] FN_SLTU = 6'b101011;
    localparam logic [OPC_W-1:0] FN_CLZ  = 6'b100000;
    localparam logic [OPC_W-1:0] FN_CLO  = 6'b100001;

    typedef enum logic [2:0] {
        K_NONE,
        K_LT_REG_S,
        K_LT_REG_U,
        K_LT_IMM_S,
        K_LT_IMM_U,
        K_LEAD_ZERO,
        K_LEAD_ONE
    } op_kind_e;

    typedef enum logic [1:0] {
        DST_NONE,
        DST_RD,
        DST_RT
    } dst_sel_e;

endpackage

// File: rtl/slc_decode.sv
module slc_decode
    import slc_pkg::*;
(
    input  logic [OPC_W-1:0] major,
    input  logic [OPC_W-1:0] funct,
    output op_kind_e         kind,
    output dst_sel_e         dst
);

    always_comb begin
        kind = K_NONE;
        unique case (major)
            MAJ_REGGRP: begin
                if (funct == FN_SLT)       kind = K_LT_REG_S;
                else if (funct == FN_SLTU) kind = K_LT_REG_U;
            end
            MAJ_EXTGRP: begin
                if (funct == FN_CLZ)       kind = K_LEAD_ZERO;
                else if (funct == FN_CLO)  kind = K_LEAD_ONE;
            end
            MAJ_SLTI:  kind = K_LT_IMM_S;
            MAJ_SLTIU: kind = K_LT_IMM_U;
            default:   kind = K_NONE;
        endcase
    end

    always_comb begin
        unique case (kind)
            K_LT_IMM_S, K_LT_IMM_U:                  dst = DST_RT;
            K_LT_REG_S, K_LT_REG_U,
            K_LEAD_ZERO, K_LEAD_ONE:                 dst = DST_RD;
            default:                                 dst = DST_NONE;
        endcase
    end

endmodule

// File: rtl/slc_compare.sv
module slc_compare #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         signed_mode,
    output logic         less
);

    logic [W:0] lhs_x;
    logic [W:0] rhs_x;
    logic [W:0] diff;

    // Extend by one bit (sign or zero) so one subtractor serves both modes.
    always_comb begin
        lhs_x = {signed_mode & lhs[W-1], lhs};
        rhs_x = {signed_mode & rhs[W-1], rhs};
        diff  = lhs_x - rhs_x;
        less  = diff[W];
    end

endmodule

// File: rtl/slc_lead_count.sv
module slc_lead_count #(
    parameter int unsigned W = 32,
    localparam int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  value,
    input  logic          match_one,
    output logic [CW-1:0] count
);

    logic [W-1:0] norm;
    logic [W-1:0] run;

    // After inversion for the ones variant, the run of zeros from the top is counted.
    always_comb begin
        norm = match_one ? ~value : value;
    end

    genvar gi;
    generate
        for (gi = W - 1; gi >= 0; gi--) begin : g_run
            if (gi == W - 1) begin : g_top
                assign run[gi] = ~norm[gi];
            end else begin : g_rest
                assign run[gi] = run[gi+1] & ~norm[gi];
            end
        end
    endgenerate

    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(run[i]);
        end
    end

    always_comb begin
        if (count == CW'(W)) begin
            assert_full_run_R5: assert (norm == '0)
                else $error("full count without uniform operand");
        end
        assert_count_range_R6: assert (count <= CW'(W))
            else $error("leading count above width");
    end

endmodule

// File: rtl/slc_exec_unit.sv
module slc_exec_unit
    import slc_pkg::*;
#(
    parameter int unsigned DW = WORD_W,
    localparam int unsigned CW = $clog2(DW + 1)
) (
    input  logic              rst,
    input  logic [31:0]       instr,
    input  logic [DW-1:0]     rs_val,
    input  logic [DW-1:0]     rt_val,
    output logic [DW-1:0]     result,
    output logic              wb_en,
    output logic [REGIX_W-1:0] wb_addr
);

    op_kind_e            kind;
    dst_sel_e            dst;
    logic [DW-1:0]       imm_ext;
    logic [DW-1:0]       cmp_rhs;
    logic                cmp_signed;
    logic                cmp_less;
    logic [CW-1:0]       lead_cnt;

    slc_decode u_dec (
        .major (instr[31:26]),
        .funct (instr[5:0]),
        .kind  (kind),
        .dst   (dst)
    );

    always_comb begin
        imm_ext    = {{(DW-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};
        cmp_rhs    = (kind == K_LT_IMM_S || kind == K_LT_IMM_U) ? imm_ext : rt_val;
        cmp_signed = (kind == K_LT_REG_S || kind == K_LT_IMM_S);
    end

    slc_compare #(.W(DW)) u_cmp (
        .lhs         (rs_val),
        .rhs         (cmp_rhs),
        .signed_mode (cmp_signed),
        .less        (cmp_less)
    );

    slc_lead_count #(.W(DW)) u_lead (
        .value     (rs_val),
        .match_one (kind == K_LEAD_ONE),
        .count     (lead_cnt)
    );

    always_comb begin
        result  = '0;
        wb_en   = 1'b0;
        wb_addr = '0;
        if (!rst) begin
            unique case (kind)
                K_LT_REG_S, K_LT_REG_U,
                K_LT_IMM_S, K_LT_IMM_U: result = {{(DW-1){1'b0}}, cmp_less};
                K_LEAD_ZERO, K_LEAD_ONE: result = DW'(lead_cnt);
                default:                 result = '0;
            endcase
            unique case (dst)
                DST_RD: begin
                    wb_en   = 1'b1;
                    wb_addr = instr[15:11];
                end
                DST_RT: begin
                    wb_en   = 1'b1;
                    wb_addr = instr[20:16];
                end
                default: begin
                    wb_en   = 1'b0;
                    wb_addr = '0;
                end
            endcase
        end
    end

    always_comb begin
        if (rst) begin
            assert_reset_idle_R9: assert (!wb_en && result == '0)
                else $error("outputs active under reset");
        end
        if (!rst && kind == K_NONE) begin
            assert_unknown_idle_R8: assert (!wb_en && result == '0 && wb_addr == '0)
                else $error("unrecognised op produced output");
        end
        if (kind == K_LT_REG_S || kind == K_LT_REG_U ||
            kind == K_LT_IMM_S || kind == K_LT_IMM_U) begin
            assert_flag_narrow_R7: assert (result[DW-1:1] == '0)
                else $error("compare result wider than one bit");
        end
        if (!rst && (kind == K_LT_IMM_S || kind == K_LT_IMM_U)) begin
            assert_imm_dest_R3: assert (wb_en && wb_addr == instr[20:16])
                else $error("immediate compare not aimed at rt");
        end
        if (!rst && (kind == K_LEAD_ZERO || kind == K_LEAD_ONE)) begin
            assert_count_dest_R5: assert (wb_en && wb_addr == instr[15:11])
                else $error("count op not aimed at rd");
        end
    end

endmodule

// File: tb/sim_slc_exec_unit.sv
module sim_slc_exec_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] instr;
    logic [31:0] rs_val;
    logic [31:0] rt_val;
    logic [31:0] result;
    logic        wb_en;
    logic [4:0]  wb_addr;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    slc_exec_unit u0 (
        .rst     (rst),
        .instr   (instr),
        .rs_val  (rs_val),
        .rt_val  (rt_val),
        .result  (result),
        .wb_en   (wb_en),
        .wb_addr (wb_addr)
    );

    logic [31:0] corners [12];
    initial begin
        corners[0]  = 32'h0000_0000; corners[1]  = 32'h0000_0001;
        corners[2]  = 32'hFFFF_FFFF; corners[3]  = 32'h7FFF_FFFF;
        corners[4]  = 32'h8000_0000; corners[5]  = 32'h8000_0001;
        corners[6]  = 32'h7FFF_FFFE; corners[7]  = 32'hFFFF_FFFE;
        corners[8]  = 32'h0000_7FFF; corners[9]  = 32'hFFFF_8000;
        corners[10] = 32'h0000_8000; corners[11] = 32'h1234_5678;
    end

    function automatic int lead_zeros(input logic [31:0] v);
        return 32 - $clog2({1'b0, v} + 33'd1);
    endfunction

    task automatic check(input string req, input logic [31:0] exp_res,
                         input logic exp_en, input logic [4:0] exp_addr);
        n_checks++;
        if (result !== exp_res || wb_en !== exp_en || wb_addr !== exp_addr) begin
            n_errors++;
            $display("FAIL %s instr=%h rs=%h rt=%h got res=%h en=%b addr=%0d exp res=%h en=%b addr=%0d",
                     req, instr, rs_val, rt_val, result, wb_en, wb_addr, exp_res, exp_en, exp_addr);
        end
    endtask

    task automatic apply(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        instr  <= ins;
        rs_val <= a;
        rt_val <= b;
        @(negedge clk);
    endtask

    function automatic logic [31:0] rtype(input logic [5:0] maj, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {maj, 5'd3, rt, rd, 5'd0, fn};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        instr = rtype(6'b000000, 5'd2, 5'd7, 6'b101010);
        rs_val = 32'h8000_0000;
        rt_val = 32'h0000_0001;
        @(negedge clk);
        check("R9", 32'd0, 1'b0, 5'd0);
        apply(rtype(6'b011100, 5'd2, 5'd9, 6'b100000), 32'd0, 32'd0);
        check("R9", 32'd0, 1'b0, 5'd0);
        rst = 1'b0;

        // Register and immediate compares over all corner pairs (R1..R4, R7)
        for (int i = 0; i < 12; i++) begin
            for (int j = 0; j < 12; j++) begin
                logic [31:0] a;
                logic [31:0] b;
                logic [4:0]  rd_ix;
                logic [4:0]  rt_ix;
                a = corners[i];
                b = corners[j];
                rd_ix = 5'((i * 7 + j) % 32);
                rt_ix = 5'((i + j * 5 + 1) % 32);
                apply(rtype(6'b000000, rt_ix, rd_ix, 6'b101010), a, b);
                check("R1", {31'd0, ($signed(a) < $signed(b))}, 1'b1, rd_ix);
                apply(rtype(6'b000000, rt_ix, rd_ix, 6'b101011), a, b);
                check("R2", {31'd0, (a < b)}, 1'b1, rd_ix);
                begin
                    logic [15:0] imm;
                    logic [31:0] bx;
                    imm = b[15:0];
                    bx  = {{16{imm[15]}}, imm};
                    apply({6'b001010, 5'd4, rt_ix, imm}, a, ~b);
                    check("R3", {31'd0, ($signed(a) < $signed(bx))}, 1'b1, rt_ix);
                    apply({6'b001011, 5'd4, rt_ix, imm}, a, ~b);
                    check("R4", {31'd0, (a < bx)}, 1'b1, rt_ix);
                end
            end
        end

        // Leading zeros / ones with the first edge at every position (R5, R6)
        for (int p = 0; p < 32; p++) begin
            logic [31:0] v;
            v = (32'd1 << p) | ((32'd1 << p) - 32'd1 & 32'hA5A5_A5A5);
            apply(rtype(6'b011100, 5'd1, 5'(p), 6'b100000), v, 32'hDEAD_BEEF);
            check("R5", 32'(31 - p), 1'b1, 5'(p));
            check("R5", 32'(lead_zeros(v)), 1'b1, 5'(p));
            apply(rtype(6'b011100, 5'd1, 5'(31 - p), 6'b100001), ~v, 32'd0);
            check("R6", 32'(31 - p), 1'b1, 5'(31 - p));
        end
        apply(rtype(6'b011100, 5'd0, 5'd12, 6'b100000), 32'h0000_0000, 32'd5);
        check("R5", 32'd32, 1'b1, 5'd12);
        apply(rtype(6'b011100, 5'd0, 5'd13, 6'b100001), 32'hFFFF_FFFF, 32'd5);
        check("R6", 32'd32, 1'b1, 5'd13);
        apply(rtype(6'b011100, 5'd0, 5'd14, 6'b100001), 32'h0000_0000, 32'd5);
        check("R6", 32'd0, 1'b1, 5'd14);
        apply(rtype(6'b011100, 5'd0, 5'd15, 6'b100000), 32'hFFFF_FFFF, 32'd5);
        check("R5", 32'd0, 1'b1, 5'd15);

        // Unrecognised encodings stay idle (R8)
        for (int m = 0; m < 64; m++) begin
            if (m != 0 && m != 10 && m != 11 && m != 28) begin
                apply(rtype(6'(m), 5'd6, 5'd8, 6'b101010), 32'h8000_0000, 32'd1);
                check("R8", 32'd0, 1'b0, 5'd0);
            end
        end
        for (int f = 0; f < 64; f++) begin
            if (f != 42 && f != 43) begin
                apply(rtype(6'b000000, 5'd6, 5'd8, 6'(f)), 32'h8000_0000, 32'd1);
                check("R8", 32'd0, 1'b0, 5'd0);
            end
            if (f != 32 && f != 33) begin
                apply(rtype(6'b011100, 5'd6, 5'd8, 6'(f)), 32'h0000_0000, 32'd1);
                check("R8", 32'd0, 1'b0, 5'd0);
            end
        end

        // Reset overrides a valid op again (R9)
        apply(rtype(6'b001010, 5'd6, 5'd8, 6'b000000), 32'h8000_0000, 32'd0);
        check("R3", 32'd1, 1'b1, 5'd6);
        rst = 1'b1;
        @(negedge clk);
        check("R9", 32'd0, 1'b0, 5'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R3", 32'd1, 1'b1, 5'd6);

        finish_run();
    end

endmodule